// File: doc/BRIEF.md
# Control-Word Register-Transfer Datapath

This block is the data side of a small processor. It holds eight general registers and carries out one register-transfer step in each clock cycle. A 16-bit control word, held for that cycle, says which two registers to read, whether the second operand is a register or an external constant, which function to apply, whether to store the function result or external input data, and which register receives it.

The two read buses also go out of the block. The first one provides a memory or I/O address and the second provides the write data. When the control word has writing turned off, the datapath can show an address and data to an external write and leave every register unchanged. Four status bits describe the current function result: overflow, carry, negative and zero. The sequencer that produces the control words sits outside this block.

Top module: `dpath_core`

## Requirements
- R1: The control word fields are destination register at bits 15:13, operand-A register at 12:10, operand-B register at 9:7, constant select at bit 6, function code at 5:2, external write-back select at bit 1 and write enable at bit 0. Register n is selected by the 3-bit binary value n.
- R2: `addr_o` always equals the register named by bits 12:10. `data_o` always equals the operand-B bus.
- R3: When bit 6 is 0, the operand-B bus carries the register named by bits 9:7. When bit 6 is 1, it carries `const_i`.
- R4: When bit 0 is 1, the destination register takes the write-back value at the rising clock edge. A read of that register in the same cycle returns its old value.
- R5: When bit 0 is 0, no register changes at the clock edge.
- R6: When bit 1 is 1, the write-back value is `data_i`. When bit 1 is 0, it is the function result.
- R7: Function codes 0000 to 0111 compute F = A + Y + code[0], taken modulo the data width. Code[2:1] selects Y: 00 gives zero, 01 gives B, 10 gives the bitwise NOT of B, and 11 gives all ones. `carry_o` is the carry out of this sum. `ovf_o` is its two's-complement overflow.
- R8: Function code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B and 1011 gives NOT A. For these codes, carry and overflow are 0.
- R9: Function code 1100 passes B. Code 1101 shifts B right by one and code 1110 shifts B left by one, and both fill the vacated bit with zero. Code 1111 passes B. For these codes, carry and overflow are 0.
- R10: `neg_o` is the MSB of the function result and `zero_o` is 1 exactly when the result is all zeros. Both come from the function result, whatever write-back source is selected.
- R11: Driving `rst_ni` low clears all eight registers at once, without waiting for a clock edge.
- R12: The word 0x2995 writes R2 + NOT R3 + 1, which is R2 - R3, into R1 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; register writes happen on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_word_i | input | 16 | Control word for the current step |
| const_i | input | DATA_W | External constant that can replace operand B |
| data_i | input | DATA_W | External data that can be written back |
| addr_o | output | DATA_W | Operand-A bus |
| data_o | output | DATA_W | Operand-B bus |
| ovf_o | output | 1 | Signed overflow of the function result |
| carry_o | output | 1 | Carry out of the function result |
| neg_o | output | 1 | MSB of the function result |
| zero_o | output | 1 | Function result is zero |

## Verification
The bench uses the default 8-bit data width. At this width, random operands regularly reach the carry and signed-overflow boundaries, and an all-zero result turns up often enough to exercise the zero flag. Random control words cover every function code, every source combination and every destination. Directed steps cover the subtraction word, a read of a register in the same cycle it is written, writes that are suppressed, and a reset asserted between clock edges.

// File: rtl/dpath_pkg.sv
package dpath_pkg;
  localparam int CW_W   = 16;
  localparam int REG_AW = 3;
  localparam int N_REGS = 1 << REG_AW;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic              b_const;
    logic [3:0]        fsel;
    logic              wb_ext;
    logic              wen;
  } ctrl_t;
endpackage

// File: rtl/dpath_regfile.sv
module dpath_regfile #(
  parameter int DW     = 8,
  parameter int AW     = 3,
  parameter int NREGS  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [NREGS-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[i] <= '0;
      else if (we_i && (waddr_i == AW'(i)))          regs_q[i] <= wdata_i;
    end
  end

  // reads bypass nothing: same-cycle write is seen next cycle
  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i)); // R4
  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> regs_q == $past(regs_q)); // R5
endmodule

// File: rtl/dpath_func_unit.sv
module dpath_func_unit #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    fsel_i,
  output logic [DW-1:0] f_o,
  output logic          ovf_o,
  output logic          carry_o,
  output logic          neg_o,
  output logic          zero_o
);
  logic [DW-1:0] y_sel;
  logic [DW:0]   sum;

  always_comb begin
    unique case (fsel_i[2:1])
      2'b00:   y_sel = '0;
      2'b01:   y_sel = b_i;
      2'b10:   y_sel = ~b_i;
      default: y_sel = '1;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, y_sel} + {{DW{1'b0}}, fsel_i[0]};

  always_comb begin
    f_o     = sum[DW-1:0];
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    if (!fsel_i[3]) begin
      carry_o = sum[DW];
      ovf_o   = (a_i[DW-1] == y_sel[DW-1]) && (sum[DW-1] != a_i[DW-1]);
    end else if (!fsel_i[2]) begin
      unique case (fsel_i[1:0])
        2'b00:   f_o = a_i & b_i;
        2'b01:   f_o = a_i | b_i;
        2'b10:   f_o = a_i ^ b_i;
        default: f_o = ~a_i;
      endcase
    end else begin
      unique case (fsel_i[1:0])
        2'b01:   f_o = {1'b0, b_i[DW-1:1]};
        2'b10:   f_o = {b_i[DW-2:0], 1'b0};
        default: f_o = b_i;
      endcase
    end
  end

  assign neg_o  = f_o[DW-1];
  assign zero_o = (f_o == '0);
endmodule

// File: rtl/dpath_core.sv
module dpath_core
  import dpath_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW_W-1:0]   ctrl_word_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] bus_a, reg_b, bus_b, func_f, bus_d;

  assign ctrl = ctrl_t'(ctrl_word_i);

  dpath_regfile #(.DW(DATA_W), .AW(REG_AW), .NREGS(N_REGS)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (ctrl.src_a),
    .raddr_b_i (ctrl.src_b),
    .we_i      (ctrl.wen),
    .waddr_i   (ctrl.dst),
    .wdata_i   (bus_d),
    .rdata_a_o (bus_a),
    .rdata_b_o (reg_b)
  );

  assign bus_b = ctrl.b_const ? const_i : reg_b;

  dpath_func_unit #(.DW(DATA_W)) i_func (
    .a_i     (bus_a),
    .b_i     (bus_b),
    .fsel_i  (ctrl.fsel),
    .f_o     (func_f),
    .ovf_o   (ovf_o),
    .carry_o (carry_o),
    .neg_o   (neg_o),
    .zero_o  (zero_o)
  );

  assign bus_d  = ctrl.wb_ext ? data_i : func_f;
  assign addr_o = bus_a;
  assign data_o = bus_b;

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> !neg_o); // R10
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.fsel[3] |-> !carry_o && !ovf_o); // R8
  AST_EXT_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.wen && ctrl.wb_ext && ctrl.src_a == ctrl.dst) |=> addr_o == $past(data_i) || ctrl.src_a != $past(ctrl.dst)); // R6
endmodule

// File: tb/test_dpath_core.sv
module test_dpath_core;
  localparam int DW   = 8;
  localparam int CLKP = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   cw = '0;
  logic [DW-1:0] k = '0, d = '0;
  logic [DW-1:0] addr_o, data_o;
  logic          ovf_o, carry_o, neg_o, zero_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] model [8];

  always #(CLKP/2) clk = ~clk;

  dpath_core #(.DATA_W(DW)) i_dpath_core (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_word_i(cw), .const_i(k), .data_i(d),
    .addr_o(addr_o), .data_o(data_o), .ovf_o(ovf_o), .carry_o(carry_o),
    .neg_o(neg_o), .zero_o(zero_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {v, c, f}
  function automatic logic [DW+1:0] model_fu(logic [DW-1:0] a, logic [DW-1:0] b, logic [3:0] fs);
    logic [DW-1:0] y, f;
    logic c, v;
    int s;
    c = 0; v = 0;
    if (fs[3] == 1'b0) begin
      case (fs[2:1])
        2'd0: y = 0;
        2'd1: y = b;
        2'd2: y = ~b;
        default: y = {DW{1'b1}};
      endcase
      s = int'(a) + int'(y) + int'(fs[0]);
      f = s[DW-1:0];
      c = s[DW];
      v = (a[DW-1] == y[DW-1]) && (f[DW-1] != a[DW-1]);
    end else begin
      case (fs)
        4'b1000: f = a & b;
        4'b1001: f = a | b;
        4'b1010: f = a ^ b;
        4'b1011: f = ~a;
        4'b1101: f = b >> 1;
        4'b1110: f = b << 1;
        default: f = b;
      endcase
    end
    return {v, c, f};
  endfunction

  function automatic logic [15:0] mk(int dst, int sa, int sb, bit mb, int fs, bit md, bit rw);
    return {dst[2:0], sa[2:0], sb[2:0], mb, fs[3:0], md, rw};
  endfunction

  // one step: drive at negedge, check mid-low phase, update model at posedge
  task automatic step(logic [15:0] w, logic [DW-1:0] kv, logic [DW-1:0] dv, bit full);
    logic [DW-1:0] ea, eb;
    logic [DW+1:0] r;
    @(negedge clk);
    cw = w; k = kv; d = dv;
    #1;
    ea = model[w[12:10]];
    eb = w[6] ? kv : model[w[9:7]];
    r  = model_fu(ea, eb, w[5:2]);
    if (full) begin
      chk("R2 addr", addr_o, ea);
      chk("R3 data", data_o, eb);
      chk(w[5] ? "R8/R9 result flags" : "R7 carry/ovf", {ovf_o, carry_o}, r[DW+1:DW]);
      chk("R10 flags", {neg_o, zero_o}, {r[DW-1], r[DW-1:0] == 0});
    end
    @(posedge clk);
    if (w[0]) model[w[15:13]] = w[1] ? dv : r[DW-1:0];
  endtask

  task automatic rd(int r, logic [DW-1:0] exp, string req);
    @(negedge clk);
    cw = mk(0, r, 0, 0, 0, 0, 0);
    #1 chk(req, addr_o, exp);
  endtask

  initial begin
    #(CLKP*200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5a5a));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) rd(i, 0, "R11 reset value");

    // R6: load registers from data_i, R1 field positions
    for (int i = 0; i < 8; i++) step(mk(i, 0, 0, 0, 0, 1, 1), 0, DW'(8'h11 * (i + 1)), 0);
    for (int i = 0; i < 8; i++) rd(i, model[i], "R6/R1 external write-back");

    // R12 subtraction word
    step(16'h2995, 0, 0, 1);
    rd(1, DW'(8'h33 - 8'h44), "R12 R1=R2-R3");

    // R4: same-cycle read returns old, next cycle new
    @(negedge clk);
    cw = mk(5, 5, 0, 0, 4'b0001, 0, 1);
    #1 chk("R4 old value in write cycle", addr_o, model[5]);
    @(posedge clk);
    model[5] = model[5] + 1;
    rd(5, model[5], "R4 value after write");

    // R5: write disabled leaves destination untouched
    step(mk(2, 0, 0, 1, 4'b1100, 0, 0), 8'hEE, 8'hDD, 1);
    rd(2, model[2], "R5 no write");

    // R3 constant, R9 shifts on boundaries
    step(mk(3, 0, 0, 1, 4'b1101, 0, 1), 8'h81, 0, 1);
    rd(3, 8'h40, "R9 right shift zero fill");
    step(mk(3, 0, 0, 1, 4'b1110, 0, 1), 8'h81, 0, 1);
    rd(3, 8'h02, "R9 left shift zero fill");
    // R7 carry/overflow corners
    step(mk(4, 0, 0, 1, 4'b1100, 0, 1), 8'h7F, 0, 1);
    step(mk(6, 4, 0, 1, 4'b0010, 0, 1), 8'h01, 0, 1);
    rd(6, 8'h80, "R7 overflow sum");
    step(mk(6, 6, 0, 1, 4'b0010, 0, 1), 8'h80, 0, 1);
    rd(6, 8'h00, "R7 carry wrap");

    // random mix
    for (int n = 0; n < 400; n++)
      step(16'($urandom), DW'($urandom), DW'($urandom), 1);
    for (int i = 0; i < 8; i++) rd(i, model[i], "R4/R6 random final state");

    // R11: async reset between edges
    @(negedge clk);
    cw = '0;
    #0.5 rst_ni = 1'b0;
    #0.5;
    for (int i = 0; i < 8; i++) model[i] = '0;
    chk("R11 async clear", addr_o, 0);
    @(posedge clk);
    #1 rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) rd(i, 0, "R11 all cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule